// File: doc/BRIEF.md
# Coded Mark Inversion Line Encoder

This block turns a serial NRZ bit stream into Coded Mark Inversion symbols for an electrical line interface. Each input bit arrives with a valid strobe at half the line clock rate. The encoder sends two half-bit symbols per bit at the full line clock rate. A zero always carries a mid-bit transition. A one is sent as a steady level, and that level changes with every one, so the line never goes long without a transition.

A mode input chooses between CMI coding and a plain NRZ path. On the NRZ path each raw bit is held for both half-bit slots. For line diagnostics, a rising edge on an asynchronous request input places exactly one code violation into the CMI stream. The ones alternation then carries on from the level that was actually sent, so the one fault shows up as one error at the far end.

Top module: `cmi_encoder`

## Requirements
- R1: In CMI mode (`mode_sel`=1), a zero bit with no violation pending is sent as 0 in the first half-bit cycle and 1 in the second.
- R2: In CMI mode, a one bit with no violation pending is sent as the same level in both half-bit cycles. That level alternates from one to one, and the first one after reset is sent low.
- R3: A bit accepted on a clock edge where `in_valid` is high drives its first half-symbol on `line_out` in the next cycle and its second half-symbol in the cycle after.
- R4: In NRZ mode (`mode_sel`=0), the raw bit appears on `line_out` for both half-bit cycles, and the ones alternation state is left unchanged.
- R5: While `rst` is high, and after reset until the first valid bit, `line_out` is low.
- R6: A violation applied to a zero bit sends the inverted zero code: 1 then 0.
- R7: A violation applied to a one bit sends that one at the level of the previous one, in both halves. The one after it is sent at the opposite of the level actually sent.
- R8: Each rising edge of `viol_req` produces exactly one violation. Further rising edges that arrive while that violation is still pending are merged into it.
- R9: A pending violation is not used by NRZ-mode bits. It is applied to the first CMI-mode bit that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock (full symbol rate) |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe marking a new input bit, at most every other cycle |
| in_bit | input | 1 | NRZ data bit |
| mode_sel | input | 1 | 1 = CMI coding, 0 = NRZ pass-through |
| viol_req | input | 1 | Asynchronous violation request; each rising edge requests one violation |
| line_out | output | 1 | Serial line symbol stream |

## Verification
The hardest cases to reach from the ports involve the violation request. The request crosses a synchroniser, so it takes effect some cycles after the input edge, and then it waits for a suitable bit. The stimulus raises the request, holds it long enough to pass the synchroniser, and only then sends the target bit. To reach the merge case, the stimulus pulses the request twice before sending any bit, then checks that only one violation appears. The same approach covers the other violation cases:
- a violation held pending across NRZ-mode bits and then applied to the first CMI bit;
- a violation on a one, followed by further ones, to check that the alternation continues from the level actually sent.

// File: rtl/cmi_pkg.sv
package cmi_pkg;

    typedef enum logic {
        MODE_NRZ = 1'b0,
        MODE_CMI = 1'b1
    } line_mode_e;

    typedef struct packed {
        logic first;
        logic second;
    } sym_pair_t;

    localparam int DEFAULT_SYNC_STAGES = 2;

    // Half-bit symbol pair for one input bit.
    // lvl is the level the next one is sent at (when no violation).
    function automatic sym_pair_t cmi_code(input logic data, input logic lvl,
                                           input logic viol);
        sym_pair_t p;
        if (data) begin
            p.first  = viol ? ~lvl : lvl;
            p.second = p.first;
        end else begin
            p.first  = viol;
            p.second = ~viol;
        end
        return p;
    endfunction

    function automatic sym_pair_t nrz_code(input logic data);
        sym_pair_t p;
        p.first  = data;
        p.second = data;
        return p;
    endfunction

endpackage

// File: rtl/cmi_viol_ctl.sv
module cmi_viol_ctl
    import cmi_pkg::*;
#(
    parameter int SYNC_STAGES = DEFAULT_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic req_async,
    input  logic consume,
    output logic pending,
    output logic req_rise
);
    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    generate
        for (genvar g = 0; g < CHAIN; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= req_async;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign req_rise = chain_q[CHAIN-2] & ~chain_q[CHAIN-1];

    always_ff @(posedge clk) begin
        if (rst) pending <= 1'b0;
        else     pending <= req_rise | (pending & ~consume);
    end

    assert_consume_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (consume && !req_rise) |=> !pending);
    assert_rise_sets_R8: assert property (@(posedge clk) disable iff (rst)
        req_rise |=> pending);

endmodule

// File: rtl/cmi_sym_gen.sv
module cmi_sym_gen
    import cmi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_valid,
    input  logic       bit_data,
    input  line_mode_e mode,
    input  logic       viol_pending,
    output sym_pair_t  pair,
    output logic       viol_consume,
    output logic       ones_lvl
);
    logic      cmi_bit;
    logic      apply_viol;
    sym_pair_t cmi_pair;

    assign cmi_bit      = bit_valid && (mode == MODE_CMI);
    assign apply_viol   = cmi_bit && viol_pending;
    assign viol_consume = apply_viol;

    always_comb begin
        cmi_pair = cmi_code(bit_data, ones_lvl, viol_pending);
        pair     = (mode == MODE_CMI) ? cmi_pair : nrz_code(bit_data);
    end

    // Next ones level follows the level actually sent on the line.
    always_ff @(posedge clk) begin
        if (rst)
            ones_lvl <= 1'b0;
        else if (cmi_bit && bit_data)
            ones_lvl <= ~cmi_pair.first;
    end

    assert_ones_alternate_R2: assert property (@(posedge clk) disable iff (rst)
        (cmi_bit && bit_data && !viol_pending) |=> (ones_lvl != $past(ones_lvl)));
    assert_viol_one_keeps_R7: assert property (@(posedge clk) disable iff (rst)
        (cmi_bit && bit_data && viol_pending) |=> $stable(ones_lvl));
    assert_nrz_freezes_R4: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && mode == MODE_NRZ) |=> $stable(ones_lvl));

endmodule

// File: rtl/cmi_serializer.sv
module cmi_serializer
    import cmi_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  sym_pair_t pair,
    output logic      line_out
);
    logic out_q;
    logic second_q;
    logic phase_q;
    logic started_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q     <= 1'b0;
            second_q  <= 1'b0;
            phase_q   <= 1'b0;
            started_q <= 1'b0;
        end else if (load) begin
            out_q     <= pair.first;
            second_q  <= pair.second;
            phase_q   <= 1'b1;
            started_q <= 1'b1;
        end else if (phase_q) begin
            out_q   <= second_q;
            phase_q <= 1'b0;
        end
    end

    assign line_out = out_q;

    assert_idle_low_R5: assert property (@(posedge clk) disable iff (rst)
        !started_q |-> !line_out);
    assert_second_half_R3: assert property (@(posedge clk) disable iff (rst)
        (phase_q && !load) |=> (line_out == $past(second_q)));

endmodule

// File: rtl/cmi_encoder.sv
module cmi_encoder
    import cmi_pkg::*;
#(
    parameter int SYNC_STAGES = DEFAULT_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_bit,
    input  logic mode_sel,
    input  logic viol_req,
    output logic line_out
);
    line_mode_e mode;
    sym_pair_t  pair;
    logic       pending;
    logic       rise;
    logic       consume;
    logic       ones_lvl;

    assign mode = line_mode_e'(mode_sel);

    cmi_viol_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_viol (
        .clk       (clk),
        .rst       (rst),
        .req_async (viol_req),
        .consume   (consume),
        .pending   (pending),
        .req_rise  (rise)
    );

    cmi_sym_gen u_gen (
        .clk          (clk),
        .rst          (rst),
        .bit_valid    (in_valid),
        .bit_data     (in_bit),
        .mode         (mode),
        .viol_pending (pending),
        .pair         (pair),
        .viol_consume (consume),
        .ones_lvl     (ones_lvl)
    );

    cmi_serializer u_ser (
        .clk      (clk),
        .rst      (rst),
        .load     (in_valid),
        .pair     (pair),
        .line_out (line_out)
    );

    assert_zero_code_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_sel && !in_bit && !pending) |=> !line_out);
    assert_zero_viol_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_sel && !in_bit && pending) |=> line_out);
    assert_nrz_path_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mode_sel) |=> (line_out == $past(in_bit)));
    assert_nrz_keeps_viol_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mode_sel && pending) |=> pending);

endmodule

// File: tb/cmi_encoder_test.sv
module cmi_encoder_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic mode_sel = 1'b1;
    logic viol_req = 1'b0;
    logic line_out;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic  val;
        string req;
    } exp_t;

    exp_t exp_q[$];

    logic model_lvl  = 1'b0;
    logic model_viol = 1'b0;

    always #5 clk = ~clk;

    cmi_encoder uut (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_bit   (in_bit),
        .mode_sel (mode_sel),
        .viol_req (viol_req),
        .line_out (line_out)
    );

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: line_out=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: pops expected symbols shortly after each edge.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(line_out, e.val, e.req);
        end
    end

    // Driver: one bit, then one idle cycle.
    task automatic send_bit(input logic b, input logic cmi);
        exp_t e1, e2;
        string tag;
        @(negedge clk);
        in_valid = 1'b1;
        in_bit   = b;
        mode_sel = cmi;
        if (!cmi) begin
            tag = "R4";
            e1.val = b; e2.val = b;
        end else if (!b) begin
            tag = model_viol ? "R6 R9" : "R1 R3";
            e1.val = model_viol; e2.val = ~model_viol;
            model_viol = 1'b0;
        end else begin
            tag = model_viol ? "R7 R9" : "R2 R3";
            e1.val = model_viol ? ~model_lvl : model_lvl;
            e2.val = e1.val;
            model_lvl  = ~e1.val;
            model_viol = 1'b0;
        end
        e1.req = tag; e2.req = tag;
        exp_q.push_back(e1);
        exp_q.push_back(e2);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pulse_viol();
        @(negedge clk);
        viol_req = 1'b1;
        repeat (3) @(negedge clk);
        viol_req = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(line_out, 1'b0, "R5 in reset");
        rst = 1'b0;
        repeat (4) begin
            @(negedge clk);
            check(line_out, 1'b0, "R5 idle before first bit");
        end

        // Plain CMI patterns
        send_bit(1'b0, 1'b1);
        send_bit(1'b1, 1'b1);
        send_bit(1'b1, 1'b1);
        send_bit(1'b0, 1'b1);
        send_bit(1'b1, 1'b1);
        send_bit(1'b0, 1'b1);
        send_bit(1'b0, 1'b1);
        send_bit(1'b1, 1'b1);
        for (int i = 0; i < 16; i++) send_bit(logic'((i * 5 + 3) % 3 == 0), 1'b1);

        // NRZ pass-through keeps alternation
        send_bit(1'b1, 1'b0);
        send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b0);
        send_bit(1'b1, 1'b1);

        // Violation on a zero
        pulse_viol(); model_viol = 1'b1;
        send_bit(1'b0, 1'b1);
        send_bit(1'b0, 1'b1);

        // Violation on a one, then following ones
        pulse_viol(); model_viol = 1'b1;
        send_bit(1'b1, 1'b1);
        send_bit(1'b1, 1'b1);
        send_bit(1'b1, 1'b1);
        send_bit(1'b0, 1'b1);

        // Two requests merged into one violation (R8)
        pulse_viol();
        pulse_viol(); model_viol = 1'b1;
        send_bit(1'b1, 1'b1);
        send_bit(1'b1, 1'b1);
        send_bit(1'b0, 1'b1);
        send_bit(1'b1, 1'b1);

        // Pending violation held across NRZ bits (R9)
        pulse_viol(); model_viol = 1'b1;
        send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b0);
        send_bit(1'b0, 1'b1);
        send_bit(1'b0, 1'b1);
        send_bit(1'b1, 1'b1);

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R3: %0d symbols not observed, expected 0", exp_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule